// File: doc/BRIEF.md
# Three-Wire Serial Programming Port for a Dual-Loop Synthesizer

This block receives configuration frames for two frequency-synthesis loops over three slow pins: a serial clock, a serial data line and a load strobe. All three pins are brought into the system clock domain through synchronisers. Edge detection is done there as well, so every internal update is a single clean cycle.

Each rising edge of the serial clock shifts one data bit into a 23-bit frame register. The frame is sent most-significant bit first, so the last two bits to arrive are the two routing bits. A rising edge of the load strobe copies the 21 payload bits into one of four holding slots. The two routing bits choose the slot: reference settings for the lower or higher loop, or divider (N/A) settings for the lower or higher loop.

The reference slots are decoded into a 14-bit divide ratio, a 2-bit output-mode field and a charge-pump current select. The divider slots are presented as raw 21-bit words. Every slot has a valid flag that rises on its first write.

Top module: `synth_serial_loader`

## Requirements
- R1: Each rising edge of `sclk_i` shifts exactly one bit of `sdata_i` into the frame register. Bits are sent most-significant first, so after 23 clocks frame bit 0 holds the last bit sent.
- R2: A rising edge of `sle_i` writes only the addressed slot. The other three slots keep their contents and their valid flags.
- R3: The slot address is taken from frame bit 0 (first routing bit) and frame bit 1 (second routing bit), as follows:
  - bit1=0, bit0=0: lower-loop reference slot.
  - bit1=0, bit0=1: higher-loop reference slot.
  - bit1=1, bit0=0: lower-loop divider slot.
  - bit1=1, bit0=1: higher-loop divider slot.
- R4: A reference slot decodes the frame fields as follows. Frame bits 22..19 are don't-care and reach no output.
  - Frame bit 2 drives mode bit 0, and frame bit 3 drives mode bit 1.
  - Frame bits 17..4 drive the ratio, with frame bit 4 as the ratio's least significant bit.
  - Frame bit 18 drives the charge-pump select.
- R5: A divider slot outputs frame bits 22..2 as a 21-bit word. Frame bit 2 drives word bit 0.
- R6: When more than 23 bits are clocked in before the load strobe, only the last 23 bits form the frame.
- R7: After reset, every slot output is zero and every valid flag is low.
- R8: A slot's valid flag goes high on the first write to that slot and stays high until reset.
- R9: Slot outputs change only on a load-strobe rising edge. Serial clocking without a strobe edge, or a strobe held high, leaves every output unchanged.
- R10: Slot outputs reflect a strobe rising edge no later than 4 system clocks after the edge appears at `sle_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| sdata_i | input | 1 | Serial data pin |
| sle_i | input | 1 | Load strobe pin |
| lo_ratio_o | output | 14 | Lower-loop reference divide ratio |
| lo_mode_o | output | 2 | Lower-loop output-mode bits |
| lo_cp_o | output | 1 | Lower-loop charge-pump current select |
| lo_ref_vld_o | output | 1 | Lower-loop reference slot written |
| hi_ratio_o | output | 14 | Higher-loop reference divide ratio |
| hi_mode_o | output | 2 | Higher-loop output-mode bits |
| hi_cp_o | output | 1 | Higher-loop charge-pump current select |
| hi_ref_vld_o | output | 1 | Higher-loop reference slot written |
| lo_nd_word_o | output | 21 | Lower-loop divider slot payload |
| lo_nd_vld_o | output | 1 | Lower-loop divider slot written |
| hi_nd_word_o | output | 21 | Higher-loop divider slot payload |
| hi_nd_vld_o | output | 1 | Higher-loop divider slot written |

## Verification
Internal faults show up at the ports in different ways and at different times:
- A misaligned shift or a dropped edge corrupts the very next latched slot. It appears as shifted fields within four system clocks of the strobe.
- Wrong address decoding writes a neighbour slot. The damage shows both as a wrong value there and as an unexpectedly raised valid flag.
- Stale or spurious writes show only when the outputs are compared after stimulus that must leave them alone. For that reason, every output is checked after every frame, including frames with no strobe.

// File: rtl/synprog_pkg.sv
package synprog_pkg;
    parameter int FRAME_W   = 23;
    parameter int ROUTE_W   = 2;
    parameter int PAYLOAD_W = FRAME_W - ROUTE_W;
    parameter int RATIO_W   = 14;
    parameter int MODE_W    = 2;
    parameter int NSLOT     = 1 << ROUTE_W;

    typedef enum logic [ROUTE_W-1:0] {
        SLOT_LO_REF = 2'd0,
        SLOT_HI_REF = 2'd1,
        SLOT_LO_ND  = 2'd2,
        SLOT_HI_ND  = 2'd3
    } slot_e;
endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-1:0], pin_i};
        level_o    = st_q.chain[STAGES-1];
        rise_o     = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R1
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int W = synprog_pkg::FRAME_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_i) st_d.sr = {st_q.sr[W-2:0], bit_i};
        word_o = st_q.sr;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R9
    hold_no_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_i |=> $stable(word_o));
endmodule

// File: rtl/latch_bank.sv
module latch_bank #(
    parameter int PW     = synprog_pkg::PAYLOAD_W,
    parameter int NSLOT  = synprog_pkg::NSLOT,
    localparam int AW    = $clog2(NSLOT)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      load_i,
    input  logic [AW-1:0]             slot_i,
    input  logic [PW-1:0]             payload_i,
    output logic [NSLOT-1:0][PW-1:0]  slots_o,
    output logic [NSLOT-1:0]          vld_o
);
    typedef struct packed {
        logic [NSLOT-1:0][PW-1:0] word;
        logic [NSLOT-1:0]         vld;
    } bank_t;

    bank_t            st_d, st_q;
    logic [NSLOT-1:0] wr;

    for (genvar i = 0; i < NSLOT; i++) begin : g_sel
        assign wr[i] = load_i && (slot_i == AW'(i));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSLOT; i++) begin
            if (wr[i]) begin
                st_d.word[i] = payload_i;
                st_d.vld[i]  = 1'b1;
            end
        end
        slots_o = st_q.word;
        vld_o   = st_q.vld;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R2
    one_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(wr));

    // R9
    idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> ($stable(slots_o) && $stable(vld_o)));

    for (genvar i = 0; i < NSLOT; i++) begin : g_vchk
        // R8
        vld_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            vld_o[i] |=> vld_o[i]);
    end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
    import synprog_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 sclk_i,
    input  logic                 sdata_i,
    input  logic                 sle_i,
    output logic [RATIO_W-1:0]   lo_ratio_o,
    output logic [MODE_W-1:0]    lo_mode_o,
    output logic                 lo_cp_o,
    output logic                 lo_ref_vld_o,
    output logic [RATIO_W-1:0]   hi_ratio_o,
    output logic [MODE_W-1:0]    hi_mode_o,
    output logic                 hi_cp_o,
    output logic                 hi_ref_vld_o,
    output logic [PAYLOAD_W-1:0] lo_nd_word_o,
    output logic                 lo_nd_vld_o,
    output logic [PAYLOAD_W-1:0] hi_nd_word_o,
    output logic                 hi_nd_vld_o
);
    localparam int MODE_LSB  = 0;
    localparam int RATIO_LSB = MODE_LSB + MODE_W;
    localparam int CP_BIT    = RATIO_LSB + RATIO_W;

    logic                           sclk_rise, sle_rise, sdata_lvl;
    logic                           sclk_lvl, sle_lvl;
    logic [FRAME_W-1:0]             frame;
    logic [NSLOT-1:0][PAYLOAD_W-1:0] slots;
    logic [NSLOT-1:0]               vld;

    typedef struct packed {
        logic [ROUTE_W-1:0]   slot;
        logic [PAYLOAD_W-1:0] payload;
    } route_t;

    route_t rt;

    pin_sync_edge #(.STAGES(2)) u_sclk (
        .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(sclk_i),
        .level_o(sclk_lvl), .rise_o(sclk_rise));

    pin_sync_edge #(.STAGES(2)) u_sdat (
        .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(sdata_i),
        .level_o(sdata_lvl), .rise_o());

    pin_sync_edge #(.STAGES(2)) u_sle (
        .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(sle_i),
        .level_o(sle_lvl), .rise_o(sle_rise));

    frame_shifter #(.W(FRAME_W)) u_shf (
        .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(sclk_rise),
        .bit_i(sdata_lvl), .word_o(frame));

    always_comb begin
        rt.slot    = frame[ROUTE_W-1:0];
        rt.payload = frame[FRAME_W-1:ROUTE_W];
    end

    latch_bank #(.PW(PAYLOAD_W), .NSLOT(NSLOT)) u_bank (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sle_rise),
        .slot_i(rt.slot), .payload_i(rt.payload),
        .slots_o(slots), .vld_o(vld));

    always_comb begin
        lo_mode_o    = slots[SLOT_LO_REF][MODE_LSB +: MODE_W];
        lo_ratio_o   = slots[SLOT_LO_REF][RATIO_LSB +: RATIO_W];
        lo_cp_o      = slots[SLOT_LO_REF][CP_BIT];
        lo_ref_vld_o = vld[SLOT_LO_REF];
        hi_mode_o    = slots[SLOT_HI_REF][MODE_LSB +: MODE_W];
        hi_ratio_o   = slots[SLOT_HI_REF][RATIO_LSB +: RATIO_W];
        hi_cp_o      = slots[SLOT_HI_REF][CP_BIT];
        hi_ref_vld_o = vld[SLOT_HI_REF];
        lo_nd_word_o = slots[SLOT_LO_ND];
        lo_nd_vld_o  = vld[SLOT_LO_ND];
        hi_nd_word_o = slots[SLOT_HI_ND];
        hi_nd_vld_o  = vld[SLOT_HI_ND];
    end

    // R2
    lo_load_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sle_rise && rt.slot == SLOT_LO_REF) |=> ($stable(hi_ratio_o) && $stable(hi_nd_word_o)));

    // R9
    held_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(sle_lvl) && sle_lvl) |=> $stable(lo_nd_word_o));
endmodule

// File: tb/synth_serial_loader_test.sv
module synth_serial_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic        clk = 0, rst_n = 0;
    logic        sclk = 0, sdata = 0, sle = 0;
    logic [13:0] lo_ratio, hi_ratio;
    logic [1:0]  lo_mode, hi_mode;
    logic        lo_cp, hi_cp, lo_rv, hi_rv, lo_nv, hi_nv;
    logic [20:0] lo_nd, hi_nd;

    int checks = 0, fails = 0;
    logic [20:0] exp_w [4];
    logic        exp_v [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_serial_loader uut (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
        .lo_ratio_o(lo_ratio), .lo_mode_o(lo_mode), .lo_cp_o(lo_cp), .lo_ref_vld_o(lo_rv),
        .hi_ratio_o(hi_ratio), .hi_mode_o(hi_mode), .hi_cp_o(hi_cp), .hi_ref_vld_o(hi_rv),
        .lo_nd_word_o(lo_nd), .lo_nd_vld_o(lo_nv), .hi_nd_word_o(hi_nd), .hi_nd_vld_o(hi_nv));

    function automatic logic [22:0] ref_frame(logic hi, logic [1:0] mode,
                                              logic [13:0] ratio, logic cp, logic [3:0] junk);
        return {junk, cp, ratio, mode, 1'b0, hi};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, 32'(lo_ratio), 32'(exp_w[0][15:2]));
        chk(req, 32'(lo_mode),  32'(exp_w[0][1:0]));
        chk(req, 32'(lo_cp),    32'(exp_w[0][16]));
        chk(req, 32'(lo_rv),    32'(exp_v[0]));
        chk(req, 32'(hi_ratio), 32'(exp_w[1][15:2]));
        chk(req, 32'(hi_mode),  32'(exp_w[1][1:0]));
        chk(req, 32'(hi_cp),    32'(exp_w[1][16]));
        chk(req, 32'(hi_rv),    32'(exp_v[1]));
        chk(req, 32'(lo_nd),    32'(exp_w[2]));
        chk(req, 32'(lo_nv),    32'(exp_v[2]));
        chk(req, 32'(hi_nd),    32'(exp_w[3]));
        chk(req, 32'(hi_nv),    32'(exp_v[3]));
    endtask

    task automatic send_bits(logic [63:0] bits, int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); sdata = bits[i];
            repeat (HALF_BIT) @(negedge clk);
            sclk = 1;
            repeat (HALF_BIT) @(negedge clk);
            sclk = 0;
        end
        repeat (HALF_BIT) @(negedge clk);
    endtask

    // R10: outputs checked 4 system clocks after the strobe rises
    task automatic strobe(logic [22:0] f);
        @(negedge clk); sle = 1;
        repeat (4) @(negedge clk);
        exp_w[{f[1], f[0]}] = f[22:2];
        exp_v[{f[1], f[0]}] = 1'b1;
        check_all("R10");
        repeat (3) @(negedge clk);
        check_all("R9 held strobe");
        sle = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [22:0] f;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) begin exp_w[i] = '0; exp_v[i] = 0; end
        repeat (5) @(negedge clk);
        check_all("R7 reset");
        rst_n = 1;
        repeat (3) @(negedge clk);
        check_all("R7 after release");

        // R4: lower reference slot, with the leading don't-care bits set
        f = ref_frame(1'b0, 2'b10, 14'd3, 1'b1, 4'hF);
        send_bits(64'(f), 23); strobe(f);
        check_all("R4 lo ref");
        // R3: higher reference slot, largest ratio
        f = ref_frame(1'b1, 2'b01, 14'h3FFF, 1'b0, 4'h5);
        send_bits(64'(f), 23); strobe(f);
        check_all("R3 hi ref");
        // R5: divider slots
        f = {21'h15A5A5, 2'b10};
        send_bits(64'(f), 23); strobe(f);
        check_all("R5 lo nd");
        f = {21'h0F0F0F, 2'b11};
        send_bits(64'(f), 23); strobe(f);
        check_all("R5 hi nd");

        // R9: clocking without a strobe leaves the outputs alone
        f = {21'h1FFFFF, 2'b00};
        send_bits(64'(f), 23);
        check_all("R9 no strobe");
        strobe(f);
        check_all("R1 strobe after idle shift");

        // R6: overlong frame, only the last 23 bits count
        f = ref_frame(1'b1, 2'b11, 14'd1234, 1'b1, 4'h0);
        send_bits({34'h0, 7'h55, f}, 30); strobe(f);
        check_all("R6 overlong");

        // R1 R2 R8: random frames, every slot compared after each one
        for (int k = 0; k < 40; k++) begin
            f = 23'($urandom());
            send_bits(64'(f), 23); strobe(f);
            check_all("R2 random");
        end
        check_all("R8 flags");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule